// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a small in-order integer core with five stages: fetch, decode, execute, memory and writeback. It runs a subset of a classic 32-bit load/store instruction set: four register-register ALU operations, a word load, a word store and a branch on equality. The instruction memory and the data memory are word arrays inside the block. They are filled through two write ports while the core is held in reset.

Each register between stages carries the whole 32-bit instruction word, not pre-decoded control bits, so any stage can decode the fields it needs. Execute computes the branch target. The branch decision is fed back to fetch from the register between execute and memory. Results move to dependent instructions by operand forwarding, and a load followed at once by a user of its result costs one stall cycle. A combinational debug port reads any architectural register, so the results of a program can be checked.

Top module: `pipe5_core`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the program counter goes to 0, every inter-stage register becomes a bubble (all-zero instruction word), and all 32 general registers clear to 0.
- R2: An instruction whose bits [31:26] are 0 and whose bits [5:0] are 0x20, 0x22, 0x24 or 0x25 writes rs+rt, rs-rt, rs AND rt or rs OR rt, in that order of codes, into rd. Here rs is bits [25:21], rt is bits [20:16] and rd is bits [15:11].
- R3: Opcode 0x23 loads the data word at byte address rs + sign-extended bits [15:0] into rt. Opcode 0x2B stores rt to that address. The data memory is indexed by address bits above bit 1.
- R4: Opcode 0x04 with rs equal to rt branches to (its own PC + 4) + (sign-extended bits [15:0] shifted left by 2). The redirect happens from the memory stage, and the three instructions fetched after the branch have no effect.
- R5: When opcode 0x04 finds rs and rt unequal, fetch continues with the next sequential instruction and no instruction is lost.
- R6: An ALU result still in the execute-to-memory register is forwarded to the next instruction. When both later registers hold a write to the same source register, the younger value in the execute-to-memory register wins.
- R7: A load followed at once by an instruction that names the load's destination as rs or rt holds fetch and decode for exactly one cycle and puts a bubble into execute. The dependent instruction then receives the loaded value.
- R8: Register 0 always reads 0. A write to it is dropped, and it is never forwarded.
- R9: A value written back in a cycle is visible to the instruction that reads the same register in decode during that cycle.
- R10: An instruction word with any other opcode or function code changes no register and no memory word.
- R11: `dbg_rdata` shows the current contents of register `dbg_raddr` combinationally.
- R12: With `imem_we` or `dmem_we` high at a rising edge, the word on the matching data input is written at the matching word index. A preload write to data memory wins over a store in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_we | input | 1 | Instruction memory preload write enable |
| imem_waddr | input | $clog2(IMEM_WORDS) | Instruction memory preload word index |
| imem_wdata | input | 32 | Instruction word to preload |
| dmem_we | input | 1 | Data memory preload write enable |
| dmem_waddr | input | $clog2(DMEM_WORDS) | Data memory preload word index |
| dmem_wdata | input | 32 | Data word to preload |
| dbg_raddr | input | 5 | Register number for the debug read |
| dbg_rdata | output | 32 | Contents of the addressed register |

## Verification
An instruction fetched at the edge that leaves reset writes its result at the fifth rising edge after that. Each stall adds one cycle, and each taken branch adds three. Every test program ends in a branch-to-self, so its registers settle well inside the 80 cycles the bench lets it run after reset is released. The scoreboard is drained only after that budget. Each expected register value is compared through the debug port on a falling edge, two nanoseconds after the address is applied. The reset checks are read while reset is still held, after at least one rising edge under reset.

// File: rtl/pipe5_pkg.sv
// Shared encodings and decode helpers for the five-stage core.
// Assumes 32-bit instruction words with fixed field positions.
package pipe5_pkg;

    localparam int XLEN  = 32;
    localparam int NREGS = 32;
    localparam int RADDR = 5;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;
    localparam logic [5:0] OP_BREQ  = 6'h04;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;

    typedef enum logic [1:0] {
        SRC_RF    = 2'd0,
        SRC_EXMEM = 2'd1,
        SRC_MEMWB = 2'd2
    } fwd_src_t;

    function automatic logic is_alu(input logic [31:0] iw);
        return (iw[31:26] == OP_RTYPE) &&
               (iw[5:0] == FN_ADD || iw[5:0] == FN_SUB ||
                iw[5:0] == FN_AND || iw[5:0] == FN_OR);
    endfunction

    function automatic logic is_load(input logic [31:0] iw);
        return iw[31:26] == OP_LOAD;
    endfunction

    function automatic logic is_store(input logic [31:0] iw);
        return iw[31:26] == OP_STORE;
    endfunction

    function automatic logic is_breq(input logic [31:0] iw);
        return iw[31:26] == OP_BREQ;
    endfunction

    // Destination register; 0 means the instruction writes nothing.
    function automatic logic [RADDR-1:0] dest_of(input logic [31:0] iw);
        if (is_alu(iw))       return iw[15:11];
        else if (is_load(iw)) return iw[20:16];
        else                  return '0;
    endfunction

    function automatic logic [XLEN-1:0] alu_eval(input logic [5:0] fn,
                                                 input logic [XLEN-1:0] a,
                                                 input logic [XLEN-1:0] b);
        case (fn)
            FN_ADD:  return a + b;
            FN_SUB:  return a - b;
            FN_AND:  return a & b;
            FN_OR:   return a | b;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/pipe5_ram.sv
// Word-wide memory with one synchronous write port and one
// asynchronous read port. Contents are not reset; they are
// assumed to be preloaded before use.
module pipe5_ram #(
    parameter int WORDS = 64,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [WORDS];

    // Store one word on a write-enabled edge.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/pipe5_regfile.sv
// General register file: 32 registers, NRD combinational read ports,
// one write port. Register 0 is hard zero. A write that lands in the
// same cycle is bypassed to the readers (write-first behaviour).
module pipe5_regfile
    import pipe5_pkg::*;
#(
    parameter int NRD = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RADDR-1:0] raddr [NRD],
    output logic [XLEN-1:0]  rdata [NRD],
    input  logic             we,
    input  logic [RADDR-1:0] waddr,
    input  logic [XLEN-1:0]  wdata
);

    logic [XLEN-1:0] regs [NREGS];

    // Clear on reset, otherwise commit a non-zero-register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we && waddr != '0) begin
            regs[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        // Read port g with zero register and same-cycle write bypass.
        always_comb begin
            if (raddr[g] == '0)                 rdata[g] = '0;
            else if (we && waddr == raddr[g])   rdata[g] = wdata;
            else                                rdata[g] = regs[raddr[g]];
        end
    end

endmodule

// File: rtl/pipe5_hazard.sv
// Hazard unit: picks operand sources for execute and detects the
// load-use case. Only ALU results are forwarded from the
// execute-to-memory register; load data is forwarded from the
// memory-to-writeback register after a one-cycle stall.
module pipe5_hazard
    import pipe5_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] id_instr,
    input  logic [31:0] ex_instr,
    input  logic [31:0] mem_instr,
    input  logic [31:0] wb_instr,
    output logic        stall,
    output fwd_src_t    fwd_a,
    output fwd_src_t    fwd_b
);

    logic [RADDR-1:0] mem_dest, wb_dest, ld_dest;

    function automatic fwd_src_t pick(input logic [RADDR-1:0] src,
                                      input logic [RADDR-1:0] md,
                                      input logic [RADDR-1:0] wd);
        if (src != '0 && src == md)      return SRC_EXMEM;
        else if (src != '0 && src == wd) return SRC_MEMWB;
        else                             return SRC_RF;
    endfunction

    // Work out which older stages hold a usable result.
    always_comb begin
        mem_dest = is_alu(mem_instr) ? mem_instr[15:11] : '0;
        wb_dest  = dest_of(wb_instr);
        ld_dest  = is_load(ex_instr) ? ex_instr[20:16] : '0;
    end

    // Select operand sources and flag a load-use dependency.
    always_comb begin
        fwd_a = pick(ex_instr[25:21], mem_dest, wb_dest);
        fwd_b = pick(ex_instr[20:16], mem_dest, wb_dest);
        stall = (ld_dest != '0) &&
                (ld_dest == id_instr[25:21] || ld_dest == id_instr[20:16]);
    end

    // R7
    one_cycle_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

endmodule

// File: rtl/pipe5_core.sv
// Five-stage in-order core. Every stage register carries the full
// instruction word. Branch targets are formed in execute and the
// redirect is taken from the execute-to-memory register, flushing
// the three younger instructions. Memories are preloaded under reset.
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           imem_we,
    input  logic [IAW-1:0] imem_waddr,
    input  logic [31:0]    imem_wdata,
    input  logic           dmem_we,
    input  logic [DAW-1:0] dmem_waddr,
    input  logic [31:0]    dmem_wdata,
    input  logic [4:0]     dbg_raddr,
    output logic [31:0]    dbg_rdata
);

    // Fetch
    logic [31:0] pc, if_instr, if_pc4;
    // Fetch-to-decode register
    logic [31:0] if_id_instr, if_id_pc4;
    // Decode-to-execute register
    logic [31:0] id_ex_a, id_ex_b, id_ex_imm, id_ex_pc4, id_ex_instr;
    // Execute-to-memory register
    logic [31:0] ex_mem_res, ex_mem_sdata, ex_mem_instr;
    logic        ex_mem_cond;
    // Memory-to-writeback register
    logic [31:0] mem_wb_val, mem_wb_instr;

    logic        stall, redirect;
    fwd_src_t    fwd_a, fwd_b;
    logic [31:0] id_imm, opa, opb, ex_res, mem_val, dm_rdata;
    logic        ex_cond;
    logic [RADDR-1:0] rf_ra [3];
    logic [XLEN-1:0]  rf_rd [3];
    logic [RADDR-1:0] wb_dest;
    logic             dm_we;
    logic [DAW-1:0]   dm_waddr;
    logic [31:0]      dm_wdata;

    assign if_pc4   = pc + 32'd4;
    assign redirect = ex_mem_cond;

    pipe5_ram #(.WORDS(IMEM_WORDS), .WIDTH(32)) u_imem (
        .clk(clk), .we(imem_we), .waddr(imem_waddr), .wdata(imem_wdata),
        .raddr(pc[IAW+1:2]), .rdata(if_instr)
    );

    // Decode: register reads (rs, rt, debug) and immediate extension.
    assign rf_ra[0] = if_id_instr[25:21];
    assign rf_ra[1] = if_id_instr[20:16];
    assign rf_ra[2] = dbg_raddr;
    assign wb_dest  = dest_of(mem_wb_instr);
    assign id_imm   = {{16{if_id_instr[15]}}, if_id_instr[15:0]};
    assign dbg_rdata = rf_rd[2];

    pipe5_regfile #(.NRD(3)) u_rf (
        .clk(clk), .rst_n(rst_n), .raddr(rf_ra), .rdata(rf_rd),
        .we(wb_dest != '0), .waddr(wb_dest), .wdata(mem_wb_val)
    );

    pipe5_hazard u_haz (
        .clk(clk), .rst_n(rst_n),
        .id_instr(if_id_instr), .ex_instr(id_ex_instr),
        .mem_instr(ex_mem_instr), .wb_instr(mem_wb_instr),
        .stall(stall), .fwd_a(fwd_a), .fwd_b(fwd_b)
    );

    // Execute: operand muxes, ALU, address and branch target.
    always_comb begin
        case (fwd_a)
            SRC_EXMEM: opa = ex_mem_res;
            SRC_MEMWB: opa = mem_wb_val;
            default:   opa = id_ex_a;
        endcase
        case (fwd_b)
            SRC_EXMEM: opb = ex_mem_res;
            SRC_MEMWB: opb = mem_wb_val;
            default:   opb = id_ex_b;
        endcase
        if (is_alu(id_ex_instr))
            ex_res = alu_eval(id_ex_instr[5:0], opa, opb);
        else if (is_breq(id_ex_instr))
            ex_res = id_ex_pc4 + {id_ex_imm[29:0], 2'b00};
        else
            ex_res = opa + id_ex_imm;
        ex_cond = is_breq(id_ex_instr) && (opa == opb);
    end

    // Memory: preload has priority over a store in the same cycle.
    always_comb begin
        dm_we    = dmem_we || is_store(ex_mem_instr);
        dm_waddr = dmem_we ? dmem_waddr : ex_mem_res[DAW+1:2];
        dm_wdata = dmem_we ? dmem_wdata : ex_mem_sdata;
        mem_val  = is_load(ex_mem_instr) ? dm_rdata : ex_mem_res;
    end

    pipe5_ram #(.WORDS(DMEM_WORDS), .WIDTH(32)) u_dmem (
        .clk(clk), .we(dm_we), .waddr(dm_waddr), .wdata(dm_wdata),
        .raddr(ex_mem_res[DAW+1:2]), .rdata(dm_rdata)
    );

    // Program counter: redirect beats stall beats sequential.
    always_ff @(posedge clk) begin
        if (!rst_n)        pc <= '0;
        else if (redirect) pc <= ex_mem_res;
        else if (!stall)   pc <= if_pc4;
    end

    // Fetch-to-decode register: flushed on redirect, held on stall.
    always_ff @(posedge clk) begin
        if (!rst_n || redirect) begin
            if_id_instr <= '0;
            if_id_pc4   <= '0;
        end else if (!stall) begin
            if_id_instr <= if_instr;
            if_id_pc4   <= if_pc4;
        end
    end

    // Decode-to-execute register: bubble on redirect or stall.
    always_ff @(posedge clk) begin
        if (!rst_n || redirect || stall) begin
            id_ex_a     <= '0;
            id_ex_b     <= '0;
            id_ex_imm   <= '0;
            id_ex_pc4   <= '0;
            id_ex_instr <= '0;
        end else begin
            id_ex_a     <= rf_rd[0];
            id_ex_b     <= rf_rd[1];
            id_ex_imm   <= id_imm;
            id_ex_pc4   <= if_id_pc4;
            id_ex_instr <= if_id_instr;
        end
    end

    // Execute-to-memory register: bubble on redirect.
    always_ff @(posedge clk) begin
        if (!rst_n || redirect) begin
            ex_mem_res   <= '0;
            ex_mem_cond  <= 1'b0;
            ex_mem_sdata <= '0;
            ex_mem_instr <= '0;
        end else begin
            ex_mem_res   <= ex_res;
            ex_mem_cond  <= ex_cond;
            ex_mem_sdata <= opb;
            ex_mem_instr <= id_ex_instr;
        end
    end

    // Memory-to-writeback register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_wb_val   <= '0;
            mem_wb_instr <= '0;
        end else begin
            mem_wb_val   <= mem_val;
            mem_wb_instr <= ex_mem_instr;
        end
    end

    // R4
    flush_bubbles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (if_id_instr == '0 && id_ex_instr == '0 && ex_mem_instr == '0));

    // R4
    redirect_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> pc == $past(ex_mem_res));

    // R5
    seq_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect && !stall) |=> pc == $past(pc) + 32'd4);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !redirect) |=> ($stable(pc) && id_ex_instr == '0));

endmodule

// File: tb/sim_pipe5_core.sv
// Scoreboard bench: the driver pushes expected register values,
// the monitor drains them through the debug port.
module sim_pipe5_core;

    localparam int IW = 64;
    localparam int DW = 64;
    localparam int IAW = $clog2(IW);
    localparam int DAW = $clog2(DW);

    localparam logic [5:0] T_LW = 6'h23, T_SW = 6'h2B, T_BEQ = 6'h04;
    localparam logic [5:0] T_ADD = 6'h20, T_SUB = 6'h22, T_AND = 6'h24, T_OR = 6'h25;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           imem_we, dmem_we;
    logic [IAW-1:0] imem_waddr;
    logic [DAW-1:0] dmem_waddr;
    logic [31:0]    imem_wdata, dmem_wdata, dbg_rdata;
    logic [4:0]     dbg_raddr;

    always #10 clk = ~clk;

    pipe5_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .imem_we(imem_we), .imem_waddr(imem_waddr), .imem_wdata(imem_wdata),
        .dmem_we(dmem_we), .dmem_waddr(dmem_waddr), .dmem_wdata(dmem_wdata),
        .dbg_raddr(dbg_raddr), .dbg_rdata(dbg_rdata)
    );

    typedef struct {
        logic [4:0]  r;
        logic [31:0] v;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   fails  = 0;
    bit   finished = 0;
    event drain_req, drain_ack;

    function automatic logic [31:0] rt_w(input logic [5:0] fn, input int rd,
                                         input int rs, input int rt);
        return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction

    function automatic logic [31:0] it_w(input logic [5:0] op, input int rt,
                                         input int rs, input int imm);
        return {op, rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    task automatic put_i(input int idx, input logic [31:0] w);
        @(negedge clk);
        imem_we = 1'b1; imem_waddr = idx[IAW-1:0]; imem_wdata = w;
        @(negedge clk);
        imem_we = 1'b0;
    endtask

    task automatic put_d(input int idx, input logic [31:0] w);
        @(negedge clk);
        dmem_we = 1'b1; dmem_waddr = idx[DAW-1:0]; dmem_wdata = w;
        @(negedge clk);
        dmem_we = 1'b0;
    endtask

    task automatic expect_reg(input int r, input logic [31:0] v, input string tag);
        exp_t e;
        e.r = r[4:0]; e.v = v; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic drain();
        ->drain_req;
        @(drain_ack);
    endtask

    // Monitor: pop each expected item and compare at the debug port.
    initial begin
        forever begin
            @(drain_req);
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                @(negedge clk);
                dbg_raddr = e.r;
                #2;
                checks++;
                if (dbg_rdata !== e.v) begin
                    fails++;
                    $display("FAIL %s: r%0d actual %h expected %h",
                             e.tag, e.r, dbg_rdata, e.v);
                end
            end
            ->drain_ack;
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R4 watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; imem_we = 1'b0; dmem_we = 1'b0;
        imem_waddr = '0; dmem_waddr = '0; imem_wdata = '0; dmem_wdata = '0;
        dbg_raddr = '0;
        repeat (3) @(negedge clk);
        expect_reg(1, 32'd0, "R1 reset clear");
        drain();

        // Program A
        put_d(0, 32'd5); put_d(1, 32'd12); put_d(2, 32'hFFFF_FFF0); put_d(3, 32'd7);
        put_i(0,  it_w(T_LW, 1, 0, 0));
        put_i(1,  it_w(T_LW, 2, 0, 4));
        put_i(2,  rt_w(T_ADD, 3, 1, 2));
        put_i(3,  rt_w(T_SUB, 4, 3, 1));
        put_i(4,  rt_w(T_OR,  5, 4, 3));
        put_i(5,  rt_w(T_AND, 6, 5, 2));
        put_i(6,  rt_w(T_ADD, 0, 1, 2));
        put_i(7,  rt_w(T_ADD, 7, 0, 1));
        put_i(8,  it_w(T_SW, 3, 0, 16));
        put_i(9,  it_w(T_LW, 8, 0, 16));
        put_i(10, it_w(T_BEQ, 3, 8, 2));
        put_i(11, rt_w(T_ADD, 9, 1, 1));
        put_i(12, rt_w(T_ADD, 10, 1, 1));
        put_i(13, rt_w(T_ADD, 11, 1, 2));
        put_i(14, it_w(T_BEQ, 1, 11, 5));
        put_i(15, rt_w(T_ADD, 12, 11, 11));
        put_i(16, {6'h3F, 5'd1, 5'd13, 16'h0005});
        put_i(17, it_w(T_BEQ, 0, 0, -1));
        @(negedge clk); rst_n = 1'b1;
        repeat (80) @(negedge clk);
        expect_reg(1,  32'd5,  "R3 R12 R11 load");
        expect_reg(2,  32'd12, "R3 load");
        expect_reg(3,  32'd17, "R2 R7 add after load-use");
        expect_reg(4,  32'd12, "R2 R6 sub forwarded");
        expect_reg(5,  32'd29, "R2 R6 or two-source forward");
        expect_reg(6,  32'd12, "R2 and");
        expect_reg(0,  32'd0,  "R8 zero register write dropped");
        expect_reg(7,  32'd5,  "R8 zero register not forwarded");
        expect_reg(8,  32'd17, "R3 store then load");
        expect_reg(9,  32'd0,  "R4 flushed slot 1");
        expect_reg(10, 32'd0,  "R4 flushed slot 2");
        expect_reg(11, 32'd17, "R4 branch target");
        expect_reg(12, 32'd34, "R5 not-taken falls through");
        expect_reg(13, 32'd0,  "R10 unknown opcode ignored");
        drain();

        // Reset again: registers clear while held.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        expect_reg(3,  32'd0, "R1 reset clears r3");
        expect_reg(11, 32'd0, "R1 reset clears r11");
        drain();

        // Program B
        put_i(0,  it_w(T_LW, 1, 0, 0));
        put_i(1,  it_w(T_LW, 2, 0, 12));
        put_i(2,  rt_w(T_ADD, 3, 1, 1));
        put_i(3,  rt_w(T_ADD, 3, 3, 2));
        put_i(4,  rt_w(T_ADD, 3, 3, 3));
        put_i(5,  rt_w(T_OR,  4, 0, 0));
        put_i(6,  rt_w(T_OR,  5, 0, 0));
        put_i(7,  rt_w(T_ADD, 6, 3, 0));
        put_i(8,  rt_w(T_SUB, 7, 2, 1));
        put_i(9,  rt_w(T_SUB, 8, 1, 2));
        put_i(10, it_w(T_LW, 10, 0, 8));
        put_i(11, rt_w(T_OR, 9, 10, 2));
        put_i(12, it_w(T_BEQ, 0, 0, -1));
        @(negedge clk); rst_n = 1'b1;
        repeat (80) @(negedge clk);
        expect_reg(3,  32'd34,         "R6 younger result wins");
        expect_reg(6,  32'd34,         "R9 write-first read");
        expect_reg(7,  32'd2,          "R2 sub positive");
        expect_reg(8,  32'hFFFF_FFFE,  "R2 sub wraps");
        expect_reg(10, 32'hFFFF_FFF0,  "R3 load negative word");
        expect_reg(9,  32'hFFFF_FFF7,  "R7 load-use or");
        expect_reg(4,  32'd0,          "R2 or of zeros");
        drain();

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule